// File: doc/BRIEF.md
# Serial Register Control Port

This block is the slave end of a three-wire serial control link that programs a bank of 8-bit mode registers. A host pulls the frame-enable line low, clocks sixteen bits in on the data input, most significant bit first, and raises the frame-enable line again. A frame carries an operation bit, a 7-bit register index and an 8-bit data byte. Write frames take effect only when the frame-enable line rises after exactly sixteen serial clocks. Read frames ignore their index field. They return, over the last eight serial clocks, the register named by a pointer held in control register 11. That register's top bit can make the pointer advance after each completed read.

All three serial pins are oversampled by a system clock through synchronizer chains. The register bank is driven out as one flat vector to the rest of the device. The serial output is given as a data bit and an output-enable, which the pad combines into a three-state pin. The serial pins are plain control wires and carry no valid/ready handshake. The host sets the pace through the serial clock, so there is no back-pressure.

Top module: `ctl_serial_port`

## Requirements
- R1: While reset is held and after it releases, every register reads 0x00 and `sdo_en` is 0.
- R2: A frame is 16 bits, sent most significant bit first and sampled on rising `sck` edges. Bit 15 is the operation (0 = write, 1 = read), bits 14:8 are the index and bits 7:0 are the data.
- R3: A write frame loads its data byte into the indexed register. This happens exactly SYNC_STAGES clock cycles after the first `clk` edge that samples `frame_n` high, following exactly 16 rising `sck` edges. No register changes at any other time.
- R4: If `frame_n` rises after fewer than 16 rising `sck` edges, the frame is discarded. Nothing is written and the read pointer does not move.
- R5: If more than 16 rising `sck` edges arrive while `frame_n` is low, the frame is discarded in the same way.
- R6: A write whose index is NUM_REGS or above changes no register.
- R7: A read frame ignores its index field. It returns the register whose index is in bits 6:0 of register 11. A pointer at or above NUM_REGS returns 0x00.
- R8: `sdo_en` is 0 while `frame_n` is high and during the first 8 bits of any frame. In a read frame, `sdo` presents data bit 7 down to bit 0, changing after falling `sck` edges 8 to 15, so that rising edges 9 to 16 see one bit each.
- R9: Bit 7 of register 11 enables auto-increment. When it is 1, bits 6:0 advance by one after each completed read and wrap from 127 to 0, and bit 7 keeps its value. When it is 0, the pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Frame enable, low for the duration of a frame |
| sck | input | 1 | Serial bit clock from the host, idle low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, valid while sdo_en is 1 |
| sdo_en | output | 1 | Output enable for the three-state serial data pin |
| regs_o | output | NUM_REGS*8 | Register bank, register i in bits i*8+7:i*8 |

## Verification
Write frames are sent to several indices, and the register map filled with data derived from each index shows whether index decoding and bit order are right. Frames that stop at 15 bits, or run to 17, separate the exact-count rule from a rule that only counts up to sixteen. So do a 12-bit read and a 17-bit read, which must leave the pointer where it was. Read frames are sent with a nonzero index field, with auto-increment off and on, with the pointer at 127 and with the pointer past the implemented range. These show whether the pointer is used in place of the index, whether it advances and wraps correctly, and whether the output stays silent for the first byte.

// File: rtl/ctl_sp_pkg.sv
package ctl_sp_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = 7;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int PTR_REG    = 11;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic  rd;
    idx_t  idx;
    byte_t data;
  } frame_t;
endpackage

// File: rtl/ctl_sp_sync.sv
module ctl_sp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctl_sp_frame_rx.sv
module ctl_sp_frame_rx
  import ctl_sp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ml_s,
  input  logic   mc_s,
  input  logic   mdi_s,
  input  byte_t  rd_byte,
  output logic   wr_en,
  output logic   inc_en,
  output frame_t frame_o,
  output cnt_t   bit_cnt,
  output logic   sdo,
  output logic   sdo_en
);
  localparam cnt_t FULL = cnt_t'(FRAME_BITS);
  localparam cnt_t HALF = cnt_t'(FRAME_BITS - DATA_W);

  logic                  ml_q, mc_q, op, ovf;
  logic [FRAME_BITS-1:0] shreg;
  byte_t                 tx_sh;
  logic                  mc_rise, mc_fall, ml_rise, complete;

  assign mc_rise  = mc_s & ~mc_q;
  assign mc_fall  = ~mc_s & mc_q;
  assign ml_rise  = ml_s & ~ml_q;
  assign complete = ml_rise & (bit_cnt == FULL) & ~ovf;
  assign wr_en    = complete & ~shreg[FRAME_BITS-1];
  assign inc_en   = complete & shreg[FRAME_BITS-1];
  assign frame_o  = frame_t'(shreg);
  assign sdo      = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ml_q    <= 1'b1;
      mc_q    <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
      ovf     <= 1'b0;
      op      <= 1'b0;
      tx_sh   <= '0;
      sdo_en  <= 1'b0;
    end else begin
      ml_q <= ml_s;
      mc_q <= mc_s;
      if (ml_s) begin
        bit_cnt <= '0;
        ovf     <= 1'b0;
        op      <= 1'b0;
        sdo_en  <= 1'b0;
      end else begin
        if (mc_rise) begin
          if (bit_cnt < FULL) begin
            shreg   <= {shreg[FRAME_BITS-2:0], mdi_s};
            bit_cnt <= bit_cnt + cnt_t'(1);
            if (bit_cnt == '0) op <= mdi_s;
          end else begin
            ovf <= 1'b1;
          end
        end
        if (mc_fall && op && bit_cnt >= HALF && bit_cnt < FULL) begin
          sdo_en <= 1'b1;
          tx_sh  <= (bit_cnt == HALF) ? rd_byte : {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/ctl_sp_reg_bank.sv
module ctl_sp_reg_bank
  import ctl_sp_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  idx_t                     wr_idx,
  input  byte_t                    wr_data,
  input  logic                     inc_en,
  output byte_t                    rd_byte,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  idx_t ptr;
  assign ptr = regs_o[PTR_REG*DATA_W +: IDX_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && wr_idx == idx_t'(g)) begin
        q <= wr_data;
      end else if (inc_en && (g == PTR_REG) && q[DATA_W-1]) begin
        q <= {q[DATA_W-1], q[IDX_W-1:0] + idx_t'(1)};
      end
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == idx_t'(i)) rd_byte = regs_o[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_sp_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_n,
  input  logic                       sck,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_en,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic   ml_s, mc_s, mdi_s, wr_en, inc_en;
  frame_t frame;
  byte_t  rd_byte;
  cnt_t   bit_cnt;

  ctl_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ml (
    .clk(clk), .rst_n(rst_n), .d(frame_n), .q(ml_s));
  ctl_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mc (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(mc_s));
  ctl_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mdi (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(mdi_s));

  ctl_sp_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .ml_s(ml_s), .mc_s(mc_s), .mdi_s(mdi_s),
    .rd_byte(rd_byte), .wr_en(wr_en), .inc_en(inc_en), .frame_o(frame),
    .bit_cnt(bit_cnt), .sdo(sdo), .sdo_en(sdo_en));

  ctl_sp_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(frame.idx),
    .wr_data(frame.data), .inc_en(inc_en), .rd_byte(rd_byte), .regs_o(regs_o));
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk
  import ctl_sp_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ml_s,
  input logic                       wr_en,
  input logic                       inc_en,
  input idx_t                       wr_idx,
  input cnt_t                       bit_cnt,
  input logic                       sdo_en,
  input logic [NUM_REGS*DATA_W-1:0] regs_o
);
  byte_t ptr_b;
  assign ptr_b = regs_o[PTR_REG*DATA_W +: DATA_W];

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ml_s |=> !sdo_en);

  p_drive_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> $past(bit_cnt) == cnt_t'(FRAME_BITS - DATA_W));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inc_en) |=> $stable(regs_o));

  p_oob_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= NUM_REGS) |=> $stable(regs_o));

  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && ptr_b[DATA_W-1]) |=>
      (ptr_b[IDX_W-1:0] == idx_t'($past(ptr_b[IDX_W-1:0]) + idx_t'(1))) && ptr_b[DATA_W-1]);

  p_ptr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ptr_b[DATA_W-1]) |=> $stable(ptr_b));

  p_one_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && inc_en));
endmodule

bind ctl_serial_port ctl_serial_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ml_s(ml_s), .wr_en(wr_en), .inc_en(inc_en),
  .wr_idx(frame.idx), .bit_cnt(bit_cnt), .sdo_en(sdo_en), .regs_o(regs_o));

// File: tb/sim_ctl_serial_port.sv
module sim_ctl_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int SYNC = 2;
  localparam int HP   = 6;
  localparam int W    = NREG*8 + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [NREG*8-1:0] regs_o;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_serial_port #(.NUM_REGS(NREG), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .regs_o(regs_o));

  // behavioural reference, evaluated on raw pins each clock
  logic [7:0]  m_reg [NREG];
  logic [15:0] m_frame;
  int          m_cnt;
  bit          m_ovf, m_op, m_en, m_dat, m_mlp, m_mcp;
  logic [7:0]  m_snap;
  logic [W-1:0] expq [$];

  function automatic logic [W-1:0] pack_exp();
    logic [W-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_reg[i];
    v[W-2] = m_en;
    v[W-1] = m_en & m_dat;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) m_reg[i] = 8'h00;
      m_frame = '0; m_cnt = 0; m_ovf = 0; m_op = 0; m_en = 0; m_dat = 0;
      m_mlp = 1; m_mcp = 0; m_snap = '0;
      expq.delete();
    end else begin
      if (frame_n) begin
        if (!m_mlp && m_cnt == 16 && !m_ovf) begin
          if (!m_frame[15]) begin
            if (int'(m_frame[14:8]) < NREG) m_reg[m_frame[14:8]] = m_frame[7:0];
          end else if (m_reg[11][7]) begin
            m_reg[11][6:0] = m_reg[11][6:0] + 7'd1;
          end
        end
        m_cnt = 0; m_ovf = 0; m_op = 0; m_en = 0;
      end else begin
        if (sck && !m_mcp) begin
          if (m_cnt < 16) begin
            if (m_cnt == 0) m_op = sdi;
            m_frame = {m_frame[14:0], sdi};
            m_cnt++;
          end else m_ovf = 1;
        end
        if (!sck && m_mcp && m_op && m_cnt >= 8 && m_cnt <= 15) begin
          if (m_cnt == 8)
            m_snap = (int'(m_reg[11][6:0]) < NREG) ? m_reg[m_reg[11][6:0]] : 8'h00;
          m_en = 1;
          m_dat = m_snap[15 - m_cnt];
        end
      end
      m_mlp = frame_n; m_mcp = sck;
      expq.push_back(pack_exp());
    end
  end

  always @(negedge clk) begin
    if (rst_n && expq.size() == SYNC + 1) begin
      logic [W-1:0] e;
      e = expq.pop_front();
      n_cmp++;
      if (regs_o !== e[NREG*8-1:0]) begin
        n_bad++;
        $display("FAIL R3 bank act=%h exp=%h at %0t", regs_o, e[NREG*8-1:0], $time);
      end
      n_cmp++;
      if (sdo_en !== e[W-2] || (sdo_en & sdo) !== e[W-1]) begin
        n_bad++;
        $display("FAIL R8 sdo act=%b/%b exp=%b/%b at %0t", sdo_en, sdo_en & sdo,
                 e[W-2], e[W-1], $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic send(input bit op, input int idx, input int dat, input int nbits,
                      output logic [7:0] rb, output bit early);
    logic [15:0] w;
    w = {op, 7'(idx), 8'(dat)};
    rb = '0; early = 0;
    @(negedge clk) frame_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i < 8 && sdo_en) early = 1;
      if (i >= 8 && i < 16) rb = {rb[6:0], sdo};
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    frame_n = 1'b1;
    repeat (3*HP) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rb;
    bit early;
    logic [NREG*8-1:0] snap;
    repeat (4) @(negedge clk);
    chk("R1 regs in reset", 32'(regs_o == '0), 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 regs after reset", 32'(regs_o == '0), 32'd1);
    chk("R1 sdo_en after reset", 32'(sdo_en), 32'd0);

    send(0, 3, 8'hA5, 16, rb, early);
    chk("R2 write reg3", 32'(rg(3)), 32'hA5);
    send(0, 5, 8'h3C, 16, rb, early);
    send(0, 6, 8'h5A, 16, rb, early);
    chk("R2 write reg5", 32'(rg(5)), 32'h3C);
    chk("R3 reg6 committed", 32'(rg(6)), 32'h5A);

    send(0, 3, 8'h11, 15, rb, early);
    chk("R4 short write dropped", 32'(rg(3)), 32'hA5);
    send(0, 3, 8'h22, 17, rb, early);
    chk("R5 long write dropped", 32'(rg(3)), 32'hA5);

    snap = regs_o;
    send(0, 100, 8'hFF, 16, rb, early);
    chk("R6 out-of-range write", 32'(regs_o == snap), 32'd1);

    send(0, 11, 8'h03, 16, rb, early);
    send(1, 5, 8'h00, 16, rb, early);
    chk("R7 read uses pointer", 32'(rb), 32'hA5);
    chk("R8 quiet first byte", 32'(early), 32'd0);
    chk("R8 released after frame", 32'(sdo_en), 32'd0);
    send(1, 0, 8'h00, 16, rb, early);
    chk("R9 inc off reread", 32'(rb), 32'hA5);
    chk("R9 inc off pointer", 32'(rg(11)), 32'h03);

    send(0, 11, 8'h85, 16, rb, early);
    send(1, 0, 8'h00, 16, rb, early);
    chk("R7 read reg5", 32'(rb), 32'h3C);
    chk("R9 pointer advanced", 32'(rg(11)), 32'h86);
    send(1, 9, 8'h00, 16, rb, early);
    chk("R9 next read", 32'(rb), 32'h5A);
    chk("R9 pointer again", 32'(rg(11)), 32'h87);

    send(0, 11, 8'hFF, 16, rb, early);
    send(1, 0, 8'h00, 16, rb, early);
    chk("R7 unimplemented ptr reads 0", 32'(rb), 32'h00);
    chk("R9 wrap 127 to 0", 32'(rg(11)), 32'h80);

    send(0, 11, 8'h85, 16, rb, early);
    send(1, 0, 8'h00, 12, rb, early);
    chk("R4 short read no inc", 32'(rg(11)), 32'h85);
    send(1, 0, 8'h00, 17, rb, early);
    chk("R5 long read no inc", 32'(rg(11)), 32'h85);

    for (int i = 0; i < NREG; i++)
      if (i != 11) send(0, i, (i*29 + 7) & 8'hFF, 16, rb, early);
    for (int i = 0; i < NREG; i++)
      if (i != 11) chk("R2 map fill", 32'(rg(i)), 32'((i*29 + 7) & 8'hFF));

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule